// File: doc/BRIEF.md
# Condition Field Compare Unit

This unit produces one 4-bit condition field and merges it into a 32-bit condition register. It supports four operations. Signed and unsigned magnitude compares report less-than, greater-than and equal, and copy the summary-overflow flag into the field. A byte-match test reports whether one byte of the first operand occurs anywhere in the second operand. A flag transfer moves the overflow and carry flags into a field. The second operand of a compare can be a 16-bit immediate in place of the 64-bit register operand. A length bit selects either a full 64-bit compare or a compare of only the low words.

The execution pipeline asserts `issue` for one cycle with the operands, the current condition register and the flags. The merged register is registered and shows up on `cr_out` after that clock edge, with `res_vld` set for one cycle. Only the selected field changes. The other seven fields are copied from `cr_in`. Register reads and instruction decode take place outside the unit.

Top module: `cfc_unit`

## Requirements
- R1: While reset is asserted, and right after an asynchronous reset, `cr_out` is 0 and `res_vld` is 0.
- R2: An operation is sampled at a rising edge where `issue` is 1. Its result appears on `cr_out` after that edge, with `res_vld` at 1 for that cycle. When `issue` is 0, `cr_out` holds its value and `res_vld` is 0.
- R3: `fld_sel` = n writes field n at `cr_out` bits 31-4n down to 28-4n. All other bits equal the `cr_in` value sampled with the operation.
- R4: For compares (`op` 0 = signed, 1 = unsigned), field bit 3 is less-than, bit 2 is greater-than and bit 1 is equal. Exactly one of these three is set. Bit 0 is a copy of `so_in`.
- R5: When `dword` = 1, the signed compare treats both full 64-bit operands as two's complement.
- R6: When `dword` = 0, only bits 31:0 of each operand are compared. The signed form sign-extends them and the unsigned form zero-extends them.
- R7: The unsigned compare (`op` = 1) orders the operands as unsigned numbers.
- R8: When `use_imm` = 1 in a compare, `imm` replaces `opb`. It is sign-extended for `op` = 0 and zero-extended for `op` = 1.
- R9: Byte match (`op` = 2) writes 0x4 if `opa[7:0]` equals any byte of `opb`, and 0x0 otherwise. `so_in`, `dword` and `use_imm` have no effect on it.
- R10: Flag transfer (`op` = 3) writes `ov_in` to field bit 3, `ov32_in` to bit 2, `ca_in` to bit 1 and `ca32_in` to bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| issue | input | 1 | Operation strobe |
| op | input | 2 | 0 signed compare, 1 unsigned compare, 2 byte match, 3 flag transfer |
| dword | input | 1 | 1 = 64-bit compare, 0 = low-word compare |
| use_imm | input | 1 | Compare against the immediate instead of opb |
| fld_sel | input | 3 | Destination field index |
| opa | input | 64 | First operand |
| opb | input | 64 | Second operand |
| imm | input | 16 | Immediate operand |
| cr_in | input | 32 | Current condition register |
| so_in | input | 1 | Summary-overflow flag |
| ov_in | input | 1 | Overflow flag |
| ov32_in | input | 1 | 32-bit overflow flag |
| ca_in | input | 1 | Carry flag |
| ca32_in | input | 1 | 32-bit carry flag |
| cr_out | output | 32 | Updated condition register |
| res_vld | output | 1 | Result valid |

## Verification
The checker assumes that every input is driven to a known value at each edge where `issue` is high. It also assumes that `cr_in` and the flags sampled there belong to the operation being issued. The checker stays disabled until the internal reset release completes, so strobes sent during the synchronizer window are outside what it covers. The bench drives every field of each operation from one table at the falling edge. It raises `issue` only after it has waited out the reset synchronizer, so every strobe it checks arrives while the unit is accepting work.

// File: rtl/cfc_pkg.sv
`timescale 1ns/1ps
package cfc_pkg;
  typedef enum logic [1:0] {
    OP_SCMP   = 2'd0,
    OP_UCMP   = 2'd1,
    OP_BMATCH = 2'd2,
    OP_XFER   = 2'd3
  } cfc_op_e;

  localparam int FLD_W = 4;
  localparam int FLD_LT = 3;
  localparam int FLD_GT = 2;
  localparam int FLD_EQ = 1;
  localparam int FLD_SO = 0;
endpackage

// File: rtl/cfc_opsel.sv
`timescale 1ns/1ps
// Builds two (W+1)-bit operands so one signed compare covers every form.
module cfc_opsel #(
  parameter int W  = 64,
  parameter int IW = 16
) (
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  input  logic [IW-1:0] imm,
  input  logic          use_imm,
  input  logic          is_signed,
  input  logic          dword,
  output logic [W:0]    ax,
  output logic [W:0]    bx
);
  localparam int HW = W / 2;

  logic [W-1:0] b_src;
  logic [W-1:0] a_nar;
  logic [W-1:0] b_nar;

  always_comb begin
    b_src = use_imm ? {{(W-IW){is_signed & imm[IW-1]}}, imm} : b;
    a_nar = dword ? a : {{HW{is_signed & a[HW-1]}}, a[HW-1:0]};
    b_nar = dword ? b_src : {{HW{is_signed & b_src[HW-1]}}, b_src[HW-1:0]};
    ax    = {is_signed & a_nar[W-1], a_nar};
    bx    = {is_signed & b_nar[W-1], b_nar};
  end
endmodule

// File: rtl/cfc_magcmp.sv
`timescale 1ns/1ps
module cfc_magcmp #(
  parameter int W = 65
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic         lt,
  output logic         gt,
  output logic         eq
);
  always_comb begin
    lt = $signed(x) < $signed(y);
    eq = (x == y);
    gt = !lt && !eq;
  end
endmodule

// File: rtl/cfc_bytehit.sv
`timescale 1ns/1ps
module cfc_bytehit #(
  parameter int W = 64
) (
  input  logic [7:0]   key,
  input  logic [W-1:0] word,
  output logic         hit
);
  localparam int NB = W / 8;

  logic [NB-1:0] lane_hit;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign lane_hit[g] = (word[8*g +: 8] == key);
  end

  assign hit = |lane_hit;
endmodule

// File: rtl/cfc_fieldins.sv
`timescale 1ns/1ps
module cfc_fieldins #(
  parameter int CR_W  = 32,
  parameter int FLD_W = 4,
  localparam int NFLD  = CR_W / FLD_W,
  localparam int IDX_W = $clog2(NFLD)
) (
  input  logic [CR_W-1:0]  base,
  input  logic [FLD_W-1:0] val,
  input  logic [IDX_W-1:0] sel,
  output logic [CR_W-1:0]  merged
);
  for (genvar g = 0; g < NFLD; g++) begin : g_fld
    localparam int HI = CR_W - 1 - FLD_W * g;
    assign merged[HI -: FLD_W] = (sel == IDX_W'(g)) ? val : base[HI -: FLD_W];
  end
endmodule

// File: rtl/cfc_unit.sv
`timescale 1ns/1ps
module cfc_unit #(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 16,
  parameter int CR_W   = 32,
  localparam int FW    = cfc_pkg::FLD_W,
  localparam int NFLD  = CR_W / FW,
  localparam int IDX_W = $clog2(NFLD)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic [1:0]        op,
  input  logic              dword,
  input  logic              use_imm,
  input  logic [IDX_W-1:0]  fld_sel,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [IMM_W-1:0]  imm,
  input  logic [CR_W-1:0]   cr_in,
  input  logic              so_in,
  input  logic              ov_in,
  input  logic              ov32_in,
  input  logic              ca_in,
  input  logic              ca32_in,
  output logic [CR_W-1:0]   cr_out,
  output logic              res_vld
);
  import cfc_pkg::*;

  // reset: asynchronous assert, two-stage synchronous release
  logic [1:0] rsync;
  logic       rst_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= 2'b00;
    else        rsync <= {rsync[0], 1'b1};
  end
  assign rst_ok = rsync[1];

  cfc_op_e  op_e;
  logic     is_signed;
  logic [DATA_W:0] ax, bx;
  logic     c_lt, c_gt, c_eq;
  logic     b_hit;
  logic [FW-1:0]   fld_new;
  logic [CR_W-1:0] cr_nxt;
  logic [CR_W-1:0] cr_q;
  logic            vld_q;
  logic            vld_nxt;

  assign op_e      = cfc_op_e'(op);
  assign is_signed = (op_e == OP_SCMP);

  cfc_opsel #(.W(DATA_W), .IW(IMM_W)) u_opsel (
    .a(opa), .b(opb), .imm(imm), .use_imm(use_imm),
    .is_signed(is_signed), .dword(dword), .ax(ax), .bx(bx)
  );

  cfc_magcmp #(.W(DATA_W + 1)) u_cmp (
    .x(ax), .y(bx), .lt(c_lt), .gt(c_gt), .eq(c_eq)
  );

  cfc_bytehit #(.W(DATA_W)) u_bhit (
    .key(opa[7:0]), .word(opb), .hit(b_hit)
  );

  // next-state: field value by operation
  always_comb begin
    fld_new = '0;
    unique case (op_e)
      OP_SCMP, OP_UCMP: begin
        fld_new[FLD_LT] = c_lt;
        fld_new[FLD_GT] = c_gt;
        fld_new[FLD_EQ] = c_eq;
        fld_new[FLD_SO] = so_in;
      end
      OP_BMATCH: fld_new[FLD_GT] = b_hit;
      OP_XFER:   fld_new = {ov_in, ov32_in, ca_in, ca32_in};
      default:   fld_new = '0;
    endcase
  end

  cfc_fieldins #(.CR_W(CR_W), .FLD_W(FW)) u_ins (
    .base(cr_in), .val(fld_new), .sel(fld_sel), .merged(cr_nxt)
  );

  assign vld_nxt = issue;

  // registers, clock enable on issue
  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      cr_q  <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_nxt;
      if (issue) cr_q <= cr_nxt;
    end
  end

  assign cr_out  = cr_q;
  assign res_vld = vld_q;
endmodule

// File: rtl/cfc_unit_chk.sv
`timescale 1ns/1ps
module cfc_unit_chk #(
  parameter int CR_W  = 32,
  parameter int FW    = 4,
  localparam int IDX_W = $clog2(CR_W / FW)
) (
  input logic             clk,
  input logic             rst_ok,
  input logic             issue,
  input logic [1:0]       op,
  input logic [IDX_W-1:0] fld_sel,
  input logic [CR_W-1:0]  cr_in,
  input logic             so_in,
  input logic             ov_in,
  input logic             ov32_in,
  input logic             ca_in,
  input logic             ca32_in,
  input logic [CR_W-1:0]  cr_out,
  input logic             res_vld
);
  localparam logic [CR_W-1:0] NIB = {{(CR_W-FW){1'b0}}, {FW{1'b1}}};

  logic             issue_q;
  logic [1:0]       op_q;
  logic [IDX_W-1:0] idx_q;
  logic [CR_W-1:0]  crin_q;
  logic             so_q;
  logic [FW-1:0]    flags_q;
  logic [FW-1:0]    out_fld;
  logic [CR_W-1:0]  keep_mask;

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      issue_q <= 1'b0;
      op_q    <= '0;
      idx_q   <= '0;
      crin_q  <= '0;
      so_q    <= 1'b0;
      flags_q <= '0;
    end else begin
      issue_q <= issue;
      op_q    <= op;
      idx_q   <= fld_sel;
      crin_q  <= cr_in;
      so_q    <= so_in;
      flags_q <= {ov_in, ov32_in, ca_in, ca32_in};
    end
  end

  assign out_fld   = cr_out[CR_W - 1 - FW * int'(idx_q) -: FW];
  assign keep_mask = ~(NIB << (CR_W - FW - FW * int'(idx_q)));

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !issue |=> ($stable(cr_out) && !res_vld));
  // R2
  vld_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    issue |=> res_vld);
  // R3
  keep_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    issue_q |-> (((cr_out ^ crin_q) & keep_mask) == '0));
  // R4
  onehot_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (issue_q && !op_q[1]) |-> ($countones(out_fld[3:1]) == 1));
  // R4
  so_copy_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (issue_q && !op_q[1]) |-> (out_fld[0] == so_q));
  // R9
  bmatch_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (issue_q && op_q == 2'd2) |-> (out_fld[3] == 1'b0 && out_fld[1:0] == 2'b00));
  // R10
  xfer_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (issue_q && op_q == 2'd3) |-> (out_fld == flags_q));
endmodule

bind cfc_unit cfc_unit_chk #(.CR_W(CR_W), .FW(FW)) u_chk (
  .clk(clk), .rst_ok(rst_ok), .issue(issue), .op(op), .fld_sel(fld_sel),
  .cr_in(cr_in), .so_in(so_in), .ov_in(ov_in), .ov32_in(ov32_in),
  .ca_in(ca_in), .ca32_in(ca32_in), .cr_out(cr_out), .res_vld(res_vld)
);

// File: tb/sim_cfc_unit.sv
`timescale 1ns/1ps
module sim_cfc_unit;
  typedef struct packed {
    logic [3:0]  req;
    logic [1:0]  op;
    logic        dw;
    logic        ui;
    logic [2:0]  fld;
    logic        so;
    logic [3:0]  fl;
    logic [63:0] a;
    logic [63:0] b;
    logic [15:0] imm;
    logic [31:0] cr;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t TBL [NV] = '{
    // R5 signed 64-bit: negative vs positive
    '{4'd5, 2'd0, 1'b1, 1'b0, 3'd2, 1'b0, 4'h0, 64'hFFFFFFFFAAAAAAAA, 64'h00000000AAAAAAAA, 16'h0, 32'h0, 32'h00800000},
    // R5 reversed
    '{4'd5, 2'd0, 1'b1, 1'b0, 3'd2, 1'b0, 4'h0, 64'h00000000AAAAAAAA, 64'hFFFFFFFFAAAAAAAA, 16'h0, 32'h0, 32'h00400000},
    // R6 low words equal
    '{4'd6, 2'd0, 1'b0, 1'b0, 3'd2, 1'b0, 4'h0, 64'hFFFFFFFFAAAAAAAA, 64'h00000000AAAAAAAA, 16'h0, 32'h0, 32'h00200000},
    // R6 unsigned low words, upper halves ignored
    '{4'd6, 2'd1, 1'b0, 1'b0, 3'd0, 1'b0, 4'h0, 64'hFFFFFFFF00000001, 64'h0000000000000002, 16'h0, 32'h12345678, 32'h82345678},
    // R7 zero vs large unsigned, SO copied (R4)
    '{4'd7, 2'd1, 1'b1, 1'b0, 3'd1, 1'b1, 4'h0, 64'h0, 64'h00000000FFFF6DC1, 16'h0, 32'h50759999, 32'h59759999},
    // R7 top bit set is large unsigned
    '{4'd7, 2'd1, 1'b1, 1'b0, 3'd7, 1'b0, 4'h0, 64'h8000000000000000, 64'h1, 16'h0, 32'hFFFFFFFF, 32'hFFFFFFF4},
    // R5 same operands signed
    '{4'd5, 2'd0, 1'b1, 1'b0, 3'd7, 1'b0, 4'h0, 64'h8000000000000000, 64'h1, 16'h0, 32'hFFFFFFFF, 32'hFFFFFFF8},
    // R8 signed immediate sign-extends
    '{4'd8, 2'd0, 1'b1, 1'b1, 3'd3, 1'b0, 4'h0, 64'hFFFFFFFFFFFF8000, 64'h0, 16'h8000, 32'h0, 32'h00020000},
    // R8 unsigned immediate zero-extends
    '{4'd8, 2'd1, 1'b1, 1'b1, 3'd4, 1'b0, 4'h0, 64'h0000000000008000, 64'hFFFFFFFFFFFF8000, 16'h8000, 32'h0, 32'h00002000},
    // R8 negative immediate, SO set
    '{4'd8, 2'd0, 1'b1, 1'b1, 3'd5, 1'b1, 4'h0, 64'h0, 64'h0, 16'hFFFF, 32'h0, 32'h00000500},
    // R9 byte match, SO/dword/use_imm ignored
    '{4'd9, 2'd2, 1'b0, 1'b1, 3'd1, 1'b1, 4'h0, 64'h123456789ABCDE0F, 64'h0001030507090B0F, 16'hFFFF, 32'h0, 32'h04000000},
    // R9 no match clears field
    '{4'd9, 2'd2, 1'b1, 1'b0, 3'd1, 1'b1, 4'h0, 64'h0000000000000002, 64'h0001030507090B0F, 16'h0, 32'hFFFFFFFF, 32'hF0FFFFFF},
    // R9 match in top byte
    '{4'd9, 2'd2, 1'b1, 1'b0, 3'd6, 1'b0, 4'h0, 64'h000000000000AB00, 64'h0001030507090B0F, 16'h0, 32'h0, 32'h00000040},
    // R10 flag transfer
    '{4'd10, 2'd3, 1'b1, 1'b0, 3'd3, 1'b1, 4'hA, 64'h5, 64'h7, 16'h0, 32'h0, 32'h000A0000},
    // R10 flag transfer into field 0 (R3)
    '{4'd10, 2'd3, 1'b0, 1'b0, 3'd0, 1'b0, 4'h5, 64'h0, 64'h0, 16'h0, 32'hFFFFFFFF, 32'h5FFFFFFF},
    // R6 signed low word negative
    '{4'd6, 2'd0, 1'b0, 1'b0, 3'd0, 1'b0, 4'h0, 64'h0000000080000000, 64'h7FFFFFFF00000000, 16'h0, 32'h0, 32'h80000000}
  };

  logic        clk;
  logic        rst_n;
  logic        issue;
  logic [1:0]  op;
  logic        dword;
  logic        use_imm;
  logic [2:0]  fld_sel;
  logic [63:0] opa;
  logic [63:0] opb;
  logic [15:0] imm;
  logic [31:0] cr_in;
  logic        so_in, ov_in, ov32_in, ca_in, ca32_in;
  logic [31:0] cr_out;
  logic        res_vld;

  int checks = 0;
  int errors = 0;

  cfc_unit u0 (
    .clk(clk), .rst_n(rst_n), .issue(issue), .op(op), .dword(dword),
    .use_imm(use_imm), .fld_sel(fld_sel), .opa(opa), .opb(opb), .imm(imm),
    .cr_in(cr_in), .so_in(so_in), .ov_in(ov_in), .ov32_in(ov32_in),
    .ca_in(ca_in), .ca32_in(ca32_in), .cr_out(cr_out), .res_vld(res_vld)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp_v);
    end
  endtask

  task automatic drive(input vec_t v);
    op      = v.op;
    dword   = v.dw;
    use_imm = v.ui;
    fld_sel = v.fld;
    so_in   = v.so;
    {ov_in, ov32_in, ca_in, ca32_in} = v.fl;
    opa     = v.a;
    opb     = v.b;
    imm     = v.imm;
    cr_in   = v.cr;
    issue   = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog actual hung expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; issue = 1'b0; op = 2'd0; dword = 1'b0; use_imm = 1'b0;
    fld_sel = 3'd0; opa = '0; opb = '0; imm = '0; cr_in = '0;
    so_in = 1'b0; ov_in = 1'b0; ov32_in = 1'b0; ca_in = 1'b0; ca32_in = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 cr_out in reset", cr_out, 32'h0);
    chk("R1 res_vld in reset", {31'b0, res_vld}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 cr_out after release", cr_out, 32'h0);

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i]);
      @(negedge clk);
      issue = 1'b0;
      chk($sformatf("R%0d vector %0d cr_out", TBL[i].req, i), cr_out, TBL[i].exp);
      chk($sformatf("R2 vector %0d res_vld", i), {31'b0, res_vld}, 32'h1);
    end

    // R2: no issue, inputs change, output holds
    cr_in = 32'hDEADBEEF; op = 2'd3; {ov_in, ov32_in, ca_in, ca32_in} = 4'hF;
    fld_sel = 3'd0;
    repeat (2) @(negedge clk);
    chk("R2 hold cr_out", cr_out, 32'h80000000);
    chk("R2 idle res_vld", {31'b0, res_vld}, 32'h0);

    // R3: one field written with a busy background
    drive('{4'd3, 2'd3, 1'b0, 1'b0, 3'd4, 1'b0, 4'h0, 64'h0, 64'h0, 16'h0, 32'h76543210, 32'h76540210});
    @(negedge clk);
    issue = 1'b0;
    chk("R3 field 4 only", cr_out, 32'h76540210);

    // R1: asynchronous reset mid-run
    rst_n = 1'b0;
    #1;
    chk("R1 async cr_out", cr_out, 32'h0);
    chk("R1 async res_vld", {31'b0, res_vld}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    drive(TBL[0]);
    @(negedge clk);
    issue = 1'b0;
    chk("R5 after reset", cr_out, TBL[0].exp);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule